// File: doc/BRIEF.md
# Peak-Current PWM Timing Generator

This block is the digital timebase of a peak-current-mode flyback controller. Every switching cycle it opens the gate at the first count of the period. The pulse then ends at the earliest of three limits: the maximum-duty ceiling, a soft-start ceiling, or an external current-limit comparator flag. A leading-edge blanking window masks that flag for a fixed number of clocks after turn-on.

The switching period comes from two sources that are added together. The first is a base period taken from a digitised feedback code. It is nominal at heavy load, stretches linearly through a light-load band, and settles at a long minimum-frequency period below that band. Below a zero-duty code no pulse is produced at all. The second is a slow triangular hop offset that spreads the spectrum.

All cycle settings are captured together at the cycle boundary, so a pulse is never reshaped partway through. A one-clock strobe marks the first count of each cycle, so that neighbouring blocks such as a slope generator can lock to it.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high, `gate` is low and `cyc_strobe` is high. The first cycle after reset lasts `NOM_PERIOD` clocks and carries no pulse.
- R2: When `fb_code >= FB_GREEN_HI`, the base period is `NOM_PERIOD` clocks.
- R3: When `FB_GREEN_LO < fb_code < FB_GREEN_HI`, the base period is `NOM_PERIOD + (FB_GREEN_HI - fb_code) * GREEN_SLOPE`. When `fb_code <= FB_GREEN_LO`, it is `NOM_PERIOD + (FB_GREEN_HI - FB_GREEN_LO) * GREEN_SLOPE`.
- R4: A cycle that starts while `fb_code < FB_ZERO` keeps `gate` low for the whole cycle. Its period follows R3.
- R5: The actual period is the base period plus `hop * HOP_STEP_CYC`.
  - `hop` starts at 0 after reset and rises first.
  - It moves by exactly one after every `HOP_CYCLES` cycle boundaries.
  - It reverses direction on reaching `+HOP_N` or `-HOP_N`.
  - The new value applies from the following cycle.
- R6: With no current limit and no soft-start, `gate` is high from count 0 for `floor(period * DUTY_Q8 / 256)` clocks.
- R7: `ilim` is ignored while the in-cycle count is below `LEB_CYC`. If `ilim` is held high from an earlier count, the pulse lasts `LEB_CYC + 1` clocks.
- R8: If `ilim` is high at in-cycle count `c >= LEB_CYC` while `gate` is high, `gate` goes low from count `c+1` and stays low until the next cycle.
- R9: Soft-start ceiling.
  - While `ss_en` is high, the pulse is further capped by a level that is 0 for the first cycle that starts with `ss_en` high.
  - The level grows by `SS_INC` clocks at each following cycle boundary.
  - Dropping `ss_en` clears the level to 0.
- R10: The period, the duty ceiling and the zero-duty decision are sampled only at a cycle boundary. A change of `fb_code` during a cycle does not alter that cycle's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | FB_W | Digitised feedback level (higher means more load) |
| ilim | input | 1 | Current-limit comparator flag |
| ss_en | input | 1 | Soft-start ramp enable |
| gate | output | 1 | Power switch drive pulse |
| cyc_strobe | output | 1 | High on the first clock of each switching cycle |

## Verification
The feedback code is stepped through four regions: above the band, inside it at several codes, at and below its low end, and on both sides of the zero-duty code. Each measured cycle length is compared with the base period plus the bench's own triangle model of the hop, so an error in either term appears separately. The current-limit flag is raised before, exactly at, and after the end of blanking. This separates a blanking window that is too short or too long from a termination that comes late. Directed sequences then cover a feedback change in mid-cycle, a full hop sweep, and the soft-start ramp with its restart.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Width of every in-cycle count and period value.
    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // Settings captured together at each cycle boundary.
    typedef struct packed {
        logic run;     // pulses allowed this cycle
        cnt_t period;  // cycle length in clocks
        cnt_t on_max;  // on-time ceiling in clocks
    } cyc_cfg_t;

    // Duty ceiling: floor(per * q8 / 256).
    function automatic cnt_t duty_cap(input cnt_t per, input int unsigned q8);
        logic [CNT_W+8:0] prod;
        prod = (CNT_W+9)'(per) * (CNT_W+9)'(q8);
        return cnt_t'(prod >> 8);
    endfunction

    function automatic cnt_t min_cnt(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pwmt_period_map.sv
module pwmt_period_map
    import pwmt_pkg::*;
#(
    parameter int FB_W        = 8,
    parameter int NOM_PERIOD  = 2000,
    parameter int GREEN_SLOPE = 284,
    parameter int FB_GREEN_HI = 168,
    parameter int FB_GREEN_LO = 143,
    parameter int FB_ZERO     = 82
) (
    input  logic [FB_W-1:0] fb_code,
    output cnt_t            base_period,
    output logic            run
);
    localparam int MAX_PERIOD = NOM_PERIOD + (FB_GREEN_HI - FB_GREEN_LO) * GREEN_SLOPE;

    int depth;

    always_comb begin
        depth = FB_GREEN_HI - int'(fb_code);
        if (fb_code >= FB_W'(FB_GREEN_HI))
            base_period = cnt_t'(NOM_PERIOD);
        else if (fb_code <= FB_W'(FB_GREEN_LO))
            base_period = cnt_t'(MAX_PERIOD);
        else
            base_period = cnt_t'(NOM_PERIOD + depth * GREEN_SLOPE);
        run = (fb_code >= FB_W'(FB_ZERO));
    end

endmodule

// File: rtl/pwmt_hop.sv
module pwmt_hop #(
    parameter int HOP_N      = 8,
    parameter int HOP_CYCLES = 17,
    localparam int IDX_W     = $clog2(HOP_N + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    output logic signed [IDX_W-1:0] hop_idx
);
    localparam int CC_W = $clog2(HOP_CYCLES + 1);
    localparam logic signed [IDX_W-1:0] IDX_HI = IDX_W'(HOP_N);
    localparam logic signed [IDX_W-1:0] IDX_LO = -IDX_HI;

    logic [CC_W-1:0]         cyc_cnt;
    logic                    going_up;
    logic signed [IDX_W-1:0] idx_nxt;

    always_comb
        idx_nxt = going_up ? hop_idx + IDX_W'(1) : hop_idx - IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_cnt  <= '0;
            hop_idx  <= '0;
            going_up <= 1'b1;
        end else if (step_en) begin
            if (cyc_cnt == CC_W'(HOP_CYCLES - 1)) begin
                cyc_cnt <= '0;
                hop_idx <= idx_nxt;
                if (idx_nxt == IDX_HI || idx_nxt == IDX_LO)
                    going_up <= ~going_up;
            end else begin
                cyc_cnt <= cyc_cnt + CC_W'(1);
            end
        end
    end

    // R5: the hop index moves by at most one per clock and stays in range
    p_hop_step_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hop_idx == $past(hop_idx)) ||
                 (hop_idx == $past(hop_idx) + IDX_W'(1)) ||
                 (hop_idx == $past(hop_idx) - IDX_W'(1)));

    p_hop_range_r5: assert property (@(posedge clk) disable iff (rst)
        (hop_idx <= IDX_HI) && (hop_idx >= IDX_LO));

endmodule

// File: rtl/pwmt_softstart.sv
module pwmt_softstart
    import pwmt_pkg::*;
#(
    parameter int SS_INC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ss_en,
    input  logic step_en,
    output cnt_t ss_lvl
);
    localparam int LVL_TOP = (2 ** CNT_W) - 1;

    always_ff @(posedge clk) begin
        if (rst || !ss_en)
            ss_lvl <= '0;
        else if (step_en) begin
            if (ss_lvl > cnt_t'(LVL_TOP - SS_INC))
                ss_lvl <= cnt_t'(LVL_TOP);
            else
                ss_lvl <= ss_lvl + cnt_t'(SS_INC);
        end
    end

    // R9: while the ramp stays enabled its level never falls
    p_ss_mono_r9: assert property (@(posedge clk) disable iff (rst)
        ss_en |=> (!ss_en || ss_lvl >= $past(ss_lvl)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmt_pkg::*;
#(
    parameter int FB_W         = 8,
    // Counts are in clocks; defaults assume a 5 ns clock.
    parameter int NOM_PERIOD   = 2000,  // 100 kHz
    parameter int GREEN_SLOPE  = 284,   // clocks added per code step in band
    parameter int FB_GREEN_HI  = 168,
    parameter int FB_GREEN_LO  = 143,
    parameter int FB_ZERO      = 82,
    parameter int DUTY_Q8      = 166,   // about 65 %
    parameter int LEB_CYC      = 28,    // 140 ns
    parameter int HOP_N        = 8,
    parameter int HOP_STEP_CYC = 12,
    parameter int HOP_CYCLES   = 17,
    parameter int SS_INC       = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FB_W-1:0] fb_code,
    input  logic            ilim,
    input  logic            ss_en,
    output logic            gate,
    output logic            cyc_strobe
);
    localparam int IDX_W = $clog2(HOP_N + 1) + 1;

    cnt_t                    cnt;
    cyc_cfg_t                cur;
    cyc_cfg_t                nxt;
    logic                    term_q;
    logic                    cyc_last;
    cnt_t                    base_period;
    logic                    run_c;
    logic signed [IDX_W-1:0] hop_idx;
    cnt_t                    ss_lvl;
    cnt_t                    cap_c;
    int                      per_i;

    pwmt_period_map #(
        .FB_W(FB_W), .NOM_PERIOD(NOM_PERIOD), .GREEN_SLOPE(GREEN_SLOPE),
        .FB_GREEN_HI(FB_GREEN_HI), .FB_GREEN_LO(FB_GREEN_LO), .FB_ZERO(FB_ZERO)
    ) u_map (
        .fb_code(fb_code), .base_period(base_period), .run(run_c)
    );

    pwmt_hop #(.HOP_N(HOP_N), .HOP_CYCLES(HOP_CYCLES)) u_hop (
        .clk(clk), .rst(rst), .step_en(cyc_last), .hop_idx(hop_idx)
    );

    pwmt_softstart #(.SS_INC(SS_INC)) u_ss (
        .clk(clk), .rst(rst), .ss_en(ss_en), .step_en(cyc_last), .ss_lvl(ss_lvl)
    );

    assign cyc_last = (cnt == cur.period - cnt_t'(1));

    always_comb begin
        per_i      = int'(base_period) + int'(hop_idx) * HOP_STEP_CYC;
        nxt.period = cnt_t'(per_i);
        cap_c      = duty_cap(nxt.period, DUTY_Q8);
        nxt.on_max = ss_en ? min_cnt(cap_c, ss_lvl) : cap_c;
        nxt.run    = run_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            cur    <= '{run: 1'b0, period: cnt_t'(NOM_PERIOD), on_max: '0};
            term_q <= 1'b0;
        end else if (cyc_last) begin
            cnt    <= '0;
            cur    <= nxt;
            term_q <= 1'b0;
        end else begin
            cnt <= cnt + cnt_t'(1);
            if (gate && ilim && cnt >= cnt_t'(LEB_CYC))
                term_q <= 1'b1;
        end
    end

    assign gate       = cur.run && (cnt < cur.on_max) && !term_q;
    assign cyc_strobe = (cnt == '0);

    // R10: settings only change at a cycle boundary
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cyc_last |=> $stable(cur));

    // R8: once terminated, the gate stays low for the rest of the cycle
    p_term_low_r8: assert property (@(posedge clk) disable iff (rst)
        (term_q && !cyc_last) |=> !gate);

    // R7: inside the blanking window the pulse cannot be cut
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (gate && cnt < cnt_t'(LEB_CYC - 1) && (cnt + cnt_t'(1)) < cur.on_max) |=> gate);

    // R4: a cycle starting below the zero-duty code opens with the gate low
    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (fb_code < FB_W'(FB_ZERO)) && cyc_last |=> !gate);

endmodule

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;

    localparam int NOM   = 200;
    localparam int SLOPE = 28;
    localparam int HI    = 168;
    localparam int LO    = 143;
    localparam int ZERO  = 82;
    localparam int Q8    = 166;
    localparam int LEB   = 28;
    localparam int HSTEP = 4;
    localparam int SSINC = 30;

    // {fb_code, ilim count (-1 none), expected base period, expected width (-1 = duty cap)}
    localparam int NV = 12;
    localparam int VEC [NV][4] = '{
        '{200,  50, 200,  51},   // R2 R8
        '{200,  10, 200,  29},   // R7 held before window end
        '{200,  -1, 200,  -1},   // R6
        '{168, 100, 200, 101},   // R2 band edge
        '{160,  -1, 424,  -1},   // R3 R6
        '{150, 300, 704, 301},   // R3 R8
        '{143,  -1, 900,  -1},   // R3 band low end
        '{100, 500, 900, 501},   // R3 below band
        '{ 81,  -1, 900,   0},   // R4
        '{ 82,  28, 900,  29},   // R4 edge, R7 R8 boundary
        '{255,  -1, 200,  -1},   // R2 R6
        '{169,   0, 200,  29}    // R7
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] fb_code;
    logic       ilim;
    logic       ss_en;
    logic       gate;
    logic       cyc_strobe;

    int ilim_at;
    int len, wid, last_len, last_wid, ncyc;
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    pwm_timebase #(
        .FB_W(8), .NOM_PERIOD(NOM), .GREEN_SLOPE(SLOPE), .FB_GREEN_HI(HI),
        .FB_GREEN_LO(LO), .FB_ZERO(ZERO), .DUTY_Q8(Q8), .LEB_CYC(LEB),
        .HOP_N(2), .HOP_STEP_CYC(HSTEP), .HOP_CYCLES(2), .SS_INC(SSINC)
    ) dut (
        .clk(clk), .rst(rst), .fb_code(fb_code), .ilim(ilim), .ss_en(ss_en),
        .gate(gate), .cyc_strobe(cyc_strobe)
    );

    // Cycle length / pulse width monitor and current-limit driver
    always @(negedge clk) begin
        if (rst) begin
            len = 1; wid = 0; ncyc = 0; last_len = 0; last_wid = 0;
            ilim = 1'b0;
        end else begin
            if (cyc_strobe) begin
                last_len = len; last_wid = wid;
                len = 1; wid = int'(gate); ncyc++;
            end else begin
                len++; wid += int'(gate);
            end
            ilim = (ilim_at >= 0) && (len - 1 >= ilim_at);
        end
    end

    function automatic int hop_off(input int m);
        int s, r, t;
        if (m < 1) return 0;
        s = (m - 1) / 2;
        r = s % 8;
        t = (r <= 2) ? r : ((r <= 6) ? 4 - r : r - 8);
        return t * HSTEP;
    endfunction

    function automatic int cap(input int p);
        return (p * Q8) / 256;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!cyc_strobe);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int p;
        rst = 1'b1; fb_code = 8'd200; ss_en = 1'b0; ilim_at = -1;
        repeat (4) @(negedge clk);
        #1;
        check("R1 gate in reset", int'(gate), 0);
        check("R1 strobe in reset", int'(cyc_strobe), 1);
        rst = 1'b0;

        // R1: first cycle after reset
        wait_strobe();
        check("R1 first length", last_len, NOM);
        check("R1 first width", last_wid, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            fb_code = 8'(VEC[v][0]);
            ilim_at = VEC[v][1];
            wait_strobe();
            wait_strobe();
            p = VEC[v][2] + hop_off(ncyc - 1);
            check($sformatf("R2/R3/R5 vec%0d length", v), last_len, p);
            check($sformatf("R4/R6/R7/R8 vec%0d width", v), last_wid,
                  (VEC[v][3] < 0) ? cap(p) : VEC[v][3]);
        end

        // R5: full hop sweep at nominal load
        fb_code = 8'd200; ilim_at = -1;
        wait_strobe();
        for (int k = 0; k < 16; k++) begin
            wait_strobe();
            check("R5 hop sweep length", last_len, NOM + hop_off(ncyc - 1));
        end

        // R10: feedback change in mid-cycle does not alter that cycle
        wait_strobe();
        repeat (60) @(negedge clk);
        #1;
        fb_code = 8'd150;
        wait_strobe();
        check("R10 mid-cycle length", last_len, NOM + hop_off(ncyc - 1));
        wait_strobe();
        check("R10 next-cycle length", last_len, 704 + hop_off(ncyc - 1));

        // R9: soft-start ramp
        fb_code = 8'd200;
        wait_strobe();
        ss_en = 1'b1;
        wait_strobe();
        wait_strobe();
        check("R9 ramp first width", last_wid, 0);
        wait_strobe();
        check("R9 ramp second width", last_wid, SSINC);
        wait_strobe();
        check("R9 ramp third width", last_wid, 2 * SSINC);
        repeat (5) wait_strobe();
        check("R9 ramp saturated width", last_wid, cap(NOM + hop_off(ncyc - 1)));
        ss_en = 1'b0;
        wait_strobe();
        ss_en = 1'b1;
        wait_strobe();
        wait_strobe();
        check("R9 restart width", last_wid, 0);
        ss_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule